// File: doc/BRIEF.md
# Dual-Mode General-Purpose Timer

A 32-bit up-counting timer clocked by a functional clock and programmed through a flat register write and read port. Software stops and starts the count, picks between a one-shot run and auto-reload, sets a power-of-two prescaler, and arms a compare against a match value. A counter that passes its all-ones value raises an overflow flag. It then either reloads from the reload register or stops by clearing its own run bit. A write of any data to the fire register copies the reload value into the counter at once.

The counter's events drive three side functions. A waveform output can toggle or emit one-clock pulses around a programmable idle level, on overflow alone or on overflow and match. An input capture port latches the counter on a chosen edge of an external pin. Three sticky flags (match, overflow, capture) are cleared by writing ones. They are masked separately onto an interrupt line and a wake line.

Top module: `gp_timer`

Register map (byte address): flags 0x00, irq mask 0x04, wake mask 0x08, control 0x0C, count 0x10, reload 0x14, fire 0x18, compare 0x1C, capture 0x20. Flag bits: 0 match, 1 overflow, 2 capture. Control bits: 0 run, 1 auto-reload, 4:2 prescale value, 5 prescale enable, 6 compare enable, 7 waveform idle level, 9:8 capture edge (00 off, 01 rising, 10 falling, 11 both), 11:10 waveform trigger (00 none, 01 overflow, 10 or 11 overflow and match), 12 toggle (1) or pulse (0), 13 capture mode and 14 pin configuration (stored only).

## Requirements
- R1: After reset every register reads zero, and pwm_out, irq and wake are low.
- R2: While the run bit is set, the counter advances by one on each tick. While it is clear, the counter holds its value.
- R3: With prescale enable clear, a tick occurs every clock. With it set, a tick occurs every 2^(value+1) clocks, the first one 2^(value+1) clocks after the run bit rises.
- R4: A tick at the all-ones count sets flag bit 1. The counter then takes the reload value if auto-reload is set. Otherwise it becomes zero and the run bit clears.
- R5: A write of any data to the fire register loads the counter from the reload register on that clock.
- R6: With compare enable set, flag bit 0 sets on the clock a tick makes the counter equal to the compare register. With compare enable clear, it never sets.
- R7: Writing ones to the flags register clears those bits, a zero bit leaves its flag unchanged, and a new event in the same clock wins over the clear.
- R8: irq is high when any flag is set together with its irq mask bit. wake does the same with the wake mask.
- R9: In toggle mode the waveform output inverts on each selected event: overflow for trigger 01, and overflow or match for trigger 1x.
- R10: In pulse mode the output leaves the idle level for exactly one clock after each selected event. With trigger 00 it sits at the idle level.
- R11: A cap_in edge of the selected kind copies the counter into the capture register and sets flag bit 2. An edge of an unselected kind, or edge select 00, captures nothing.
- R12: Control reads back its 15 bits with the upper bits zero. The fire register reads zero, and count, reload and compare read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| cap_in | input | 1 | Capture pin, synchronous to clk |
| pwm_out | output | 1 | Waveform output |
| irq | output | 1 | Masked flag interrupt |
| wake | output | 1 | Masked flag wake request |

## Verification
Every cycle, the assertions check that a stopped counter holds and that overflow raises its flag. They also check that a one-shot overflow stops the run, that fire loads the reload value, and that a disabled compare never flags a match. The write-one clear of flags, capture latching the pre-edge count, and the idle waveform level under trigger 00 are checked the same way. Only the bench's scenarios can show the prescaler's tick spacing, the toggle and pulse waveforms under each trigger choice, the edge-select filtering, and the exact counts reached after a run of random length.

// File: rtl/gp_timer_pkg.sv
package gp_timer_pkg;
  localparam logic [7:0] OFS_FLAGS = 8'h00;
  localparam logic [7:0] OFS_IMASK = 8'h04;
  localparam logic [7:0] OFS_WMASK = 8'h08;
  localparam logic [7:0] OFS_CTRL  = 8'h0C;
  localparam logic [7:0] OFS_COUNT = 8'h10;
  localparam logic [7:0] OFS_RELD  = 8'h14;
  localparam logic [7:0] OFS_FIRE  = 8'h18;
  localparam logic [7:0] OFS_CMP   = 8'h1C;
  localparam logic [7:0] OFS_CAPT  = 8'h20;

  localparam int CTRL_W   = 15;
  localparam int B_RUN    = 0;
  localparam int B_AR     = 1;
  localparam int B_PSLO   = 2;
  localparam int B_PSEN   = 5;
  localparam int B_CMPEN  = 6;
  localparam int B_DFLT   = 7;
  localparam int B_EDGLO  = 8;
  localparam int B_SELLO  = 10;
  localparam int B_TOGGLE = 12;

  localparam int FLAG_W   = 3;
  localparam int F_MATCH  = 0;
  localparam int F_OVF    = 1;
  localparam int F_CAPT   = 2;

  // clocks between ticks when the prescaler is enabled
  function automatic int unsigned presc_period(input int unsigned v);
    return 32'd2 << v;
  endfunction

  // waveform trigger decode: 01 overflow, 1x overflow or match
  function automatic logic wave_event(input logic [1:0] sel, input logic ovf, input logic mat);
    return (sel == 2'b01) ? ovf : (sel[1] ? (ovf | mat) : 1'b0);
  endfunction
endpackage

// File: rtl/gp_tmr_presc.sv
module gp_tmr_presc #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            ps_en,
  input  logic [PS_W-1:0] ps_val,
  output logic            tick
);
  import gp_timer_pkg::*;
  localparam int DIV_W = 1 << PS_W;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;
  logic             hit;

  always_comb begin
    lim  = DIV_W'(presc_period(32'(ps_val)) - 1);
    hit  = (div_q == lim);
    tick = run & (~ps_en | hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              div_q <= '0;
    else if (!run || !ps_en) div_q <= '0;
    else if (hit)            div_q <= '0;
    else                     div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/gp_tmr_wave.sv
module gp_tmr_wave (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle_lvl,
  input  logic       toggle,
  input  logic [1:0] sel,
  input  logic       ovf_ev,
  input  logic       mat_ev,
  output logic       wave_ev,
  output logic       pwm_out
);
  import gp_timer_pkg::*;
  logic tgl_q, pls_q;

  assign wave_ev = wave_event(sel, ovf_ev, mat_ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_q <= 1'b0;
      pls_q <= 1'b0;
    end else if (sel == 2'b00) begin
      tgl_q <= 1'b0;
      pls_q <= 1'b0;
    end else begin
      tgl_q <= tgl_q ^ (toggle & wave_ev);
      pls_q <= ~toggle & wave_ev;
    end
  end

  assign pwm_out = idle_lvl ^ (toggle ? tgl_q : pls_q);
endmodule

// File: rtl/gp_tmr_capt.sv
module gp_tmr_capt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_in,
  input  logic [1:0]       edge_sel,
  input  logic [CNT_W-1:0] cnt,
  output logic             cap_ev,
  output logic [CNT_W-1:0] cap_val
);
  logic prev_q;

  assign cap_ev = (edge_sel[0] & cap_in & ~prev_q) | (edge_sel[1] & ~cap_in & prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      cap_val <= '0;
    end else begin
      prev_q <= cap_in;
      if (cap_ev) cap_val <= cnt;
    end
  end
endmodule

// File: rtl/gp_timer.sv
module gp_timer #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int PS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  input  logic              cap_in,
  output logic              pwm_out,
  output logic              irq,
  output logic              wake
);
  import gp_timer_pkg::*;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cnt_q, load_q, cmp_q, cap_q, cnt_nxt, tick_val;
  logic [FLAG_W-1:0] flags_q, imask_q, wmask_q, clr_bits, ev_bits;

  // named internal events
  logic wr_ctrl, wr_cnt, wr_fire, wr_flags, wr_load, wr_cmp, wr_imask, wr_wmask;
  logic run, ar, cmp_en, tick, cnt_max, ovf_ev, mat_ev, cap_ev, wave_ev;

  assign wr_ctrl  = wr_en && (addr == ADDR_W'(OFS_CTRL));
  assign wr_cnt   = wr_en && (addr == ADDR_W'(OFS_COUNT));
  assign wr_fire  = wr_en && (addr == ADDR_W'(OFS_FIRE));
  assign wr_flags = wr_en && (addr == ADDR_W'(OFS_FLAGS));
  assign wr_load  = wr_en && (addr == ADDR_W'(OFS_RELD));
  assign wr_cmp   = wr_en && (addr == ADDR_W'(OFS_CMP));
  assign wr_imask = wr_en && (addr == ADDR_W'(OFS_IMASK));
  assign wr_wmask = wr_en && (addr == ADDR_W'(OFS_WMASK));

  assign run    = ctrl_q[B_RUN];
  assign ar     = ctrl_q[B_AR];
  assign cmp_en = ctrl_q[B_CMPEN];

  gp_tmr_presc #(.PS_W(PS_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .ps_en(ctrl_q[B_PSEN]),
    .ps_val(ctrl_q[B_PSLO +: PS_W]), .tick(tick)
  );

  always_comb begin
    cnt_max  = &cnt_q;
    ovf_ev   = tick & cnt_max;
    tick_val = cnt_max ? (ar ? load_q : '0) : cnt_q + 1'b1;
    mat_ev   = cmp_en & tick & (tick_val == cmp_q);
    cnt_nxt  = tick ? tick_val : cnt_q;
    if (wr_fire) cnt_nxt = load_q;
    if (wr_cnt)  cnt_nxt = wdata;
  end

  gp_tmr_wave u_wave (
    .clk(clk), .rst_n(rst_n), .idle_lvl(ctrl_q[B_DFLT]), .toggle(ctrl_q[B_TOGGLE]),
    .sel(ctrl_q[B_SELLO +: 2]), .ovf_ev(ovf_ev), .mat_ev(mat_ev),
    .wave_ev(wave_ev), .pwm_out(pwm_out)
  );

  gp_tmr_capt #(.CNT_W(CNT_W)) u_capt (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .edge_sel(ctrl_q[B_EDGLO +: 2]),
    .cnt(cnt_q), .cap_ev(cap_ev), .cap_val(cap_q)
  );

  assign clr_bits = wr_flags ? wdata[FLAG_W-1:0] : '0;
  always_comb begin
    ev_bits          = '0;
    ev_bits[F_MATCH] = mat_ev;
    ev_bits[F_OVF]   = ovf_ev;
    ev_bits[F_CAPT]  = cap_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cnt_q   <= '0;
      load_q  <= '0;
      cmp_q   <= '0;
      flags_q <= '0;
      imask_q <= '0;
      wmask_q <= '0;
    end else begin
      cnt_q   <= cnt_nxt;
      flags_q <= (flags_q & ~clr_bits) | ev_bits;
      if (wr_ctrl)            ctrl_q <= wdata[CTRL_W-1:0];
      else if (ovf_ev && !ar) ctrl_q[B_RUN] <= 1'b0;
      if (wr_load)  load_q  <= wdata;
      if (wr_cmp)   cmp_q   <= wdata;
      if (wr_imask) imask_q <= wdata[FLAG_W-1:0];
      if (wr_wmask) wmask_q <= wdata[FLAG_W-1:0];
    end
  end

  assign irq  = |(flags_q & imask_q);
  assign wake = |(flags_q & wmask_q);

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(OFS_FLAGS): rdata = CNT_W'(flags_q);
      ADDR_W'(OFS_IMASK): rdata = CNT_W'(imask_q);
      ADDR_W'(OFS_WMASK): rdata = CNT_W'(wmask_q);
      ADDR_W'(OFS_CTRL):  rdata = CNT_W'(ctrl_q);
      ADDR_W'(OFS_COUNT): rdata = cnt_q;
      ADDR_W'(OFS_RELD):  rdata = load_q;
      ADDR_W'(OFS_CMP):   rdata = cmp_q;
      ADDR_W'(OFS_CAPT):  rdata = cap_q;
      default:            rdata = '0;
    endcase
  end
endmodule

// File: rtl/gp_timer_chk.sv
module gp_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             ar,
  input logic             cmp_en,
  input logic [1:0]       wave_sel,
  input logic             idle_lvl,
  input logic             wr_ctrl,
  input logic             wr_cnt,
  input logic             wr_fire,
  input logic             wr_flags,
  input logic [CNT_W-1:0] wdata,
  input logic             ovf_ev,
  input logic             cap_ev,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] load_q,
  input logic [CNT_W-1:0] cap_q,
  input logic [2:0]       flags_q,
  input logic             pwm_out
);
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt && !wr_fire) |=> $stable(cnt_q)); // R2
  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> flags_q[1]); // R4
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ev && !ar && !wr_ctrl) |=> !run); // R4
  AST_FIRE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (cnt_q == $past(load_q))); // R5
  AST_NO_MATCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_en && !flags_q[0]) |=> !flags_q[0]); // R6
  AST_W1C_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flags && wdata[1] && !ovf_ev) |=> !flags_q[1]); // R7
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_sel == 2'b00 && !wr_ctrl) |=> (pwm_out == idle_lvl)); // R10
  AST_CAPT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> (flags_q[2] && cap_q == $past(cnt_q))); // R11
endmodule

bind gp_timer gp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .ar(ar), .cmp_en(cmp_en),
  .wave_sel(ctrl_q[11:10]), .idle_lvl(ctrl_q[7]), .wr_ctrl(wr_ctrl),
  .wr_cnt(wr_cnt), .wr_fire(wr_fire), .wr_flags(wr_flags), .wdata(wdata),
  .ovf_ev(ovf_ev), .cap_ev(cap_ev), .cnt_q(cnt_q), .load_q(load_q),
  .cap_q(cap_q), .flags_q(flags_q), .pwm_out(pwm_out)
);

// File: tb/gp_timer_bench.sv
module gp_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_FLAGS = 8'h00, A_IMASK = 8'h04, A_WMASK = 8'h08,
    A_CTRL = 8'h0C, A_COUNT = 8'h10, A_RELD = 8'h14, A_FIRE = 8'h18,
    A_CMP = 8'h1C, A_CAPT = 8'h20;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, cap_in = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic pwm_out, irq, wake;
  int checks = 0, fails = 0;
  bit done = 0;

  gp_timer u_gp_timer (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cap_in(cap_in), .pwm_out(pwm_out),
    .irq(irq), .wake(wake));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] adv(input int k, input bit ps, input int v);
    return ps ? 32'(k / (2 << v)) : 32'(k);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic stop_clear();
    wr(A_CTRL, 0); wr(A_FLAGS, 32'h7);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    if (!done) $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, c, l;
    void'($urandom(32'd4711));
    step(2); rst_n = 1'b1; step(1);

    // R1 reset state
    rd(A_CTRL, d);  chk("R1 ctrl", d, 0);
    rd(A_COUNT, d); chk("R1 count", d, 0);
    rd(A_FLAGS, d); chk("R1 flags", d, 0);
    chk("R1 outputs", {29'd0, pwm_out, irq, wake}, 0);

    // R12 readback, R5 fire
    l = $urandom; wr(A_RELD, l); rd(A_RELD, d); chk("R12 reload", d, l);
    c = $urandom; wr(A_COUNT, c); rd(A_COUNT, d); chk("R12 count", d, c);
    wr(A_CTRL, 32'hFFFF_7FFE); rd(A_CTRL, d); chk("R12 ctrl", d, 32'h7FFE);
    rd(A_FIRE, d); chk("R12 fire reads 0", d, 0);
    wr(A_CTRL, 0);
    wr(A_FIRE, $urandom); rd(A_COUNT, d); chk("R5 fire loads", d, l);

    // R2 R3 random runs
    for (int i = 0; i < 8; i++) begin
      int v, k; bit ps;
      c = $urandom & 32'h7FFF_FFFF; v = $urandom % 4; ps = $urandom % 2;
      k = 1 + $urandom % 40;
      wr(A_CTRL, 0); wr(A_COUNT, c);
      wr(A_CTRL, 32'(1 | (int'(ps) << 5) | (v << 2)));
      step(k); rd(A_COUNT, d); chk("R3 prescaled count", d, c + adv(k, ps, v));
      wr(A_CTRL, 0); rd(A_COUNT, c); step(3); rd(A_COUNT, d); chk("R2 hold stopped", d, c);
    end

    // R4 auto-reload overflow
    stop_clear(); l = $urandom;
    wr(A_COUNT, 32'hFFFF_FFFD); wr(A_RELD, l); wr(A_CTRL, 3);
    step(3); rd(A_COUNT, d); chk("R4 reload", d, l);
    rd(A_FLAGS, d); chk("R4 ovf flag", d, 2);
    // R4 one-shot
    stop_clear(); wr(A_COUNT, 32'hFFFF_FFFF); wr(A_CTRL, 1); step(1);
    rd(A_COUNT, d); chk("R4 oneshot zero", d, 0);
    rd(A_CTRL, d);  chk("R4 run cleared", d, 0);
    step(3); rd(A_COUNT, d); chk("R4 stays stopped", d, 0);

    // R7 write-one clear, keeps other bits
    rd(A_FLAGS, d); chk("R7 pre", d, 2);

    // R6 match, R8 masks
    wr(A_FLAGS, 32'h2); rd(A_FLAGS, d); chk("R7 cleared", d, 0);
    wr(A_IMASK, 1); wr(A_WMASK, 2);
    wr(A_COUNT, 10); wr(A_CMP, 13); wr(A_CTRL, 32'h41);
    step(2); rd(A_FLAGS, d); chk("R6 before match", d, 0);
    step(1); rd(A_FLAGS, d); chk("R6 match flag", d, 1);
    chk("R8 irq", {31'd0, irq}, 1); chk("R8 wake masked", {31'd0, wake}, 0);
    wr(A_WMASK, 1); chk("R8 wake", {31'd0, wake}, 1);
    wr(A_FLAGS, 32'h2); rd(A_FLAGS, d); chk("R7 zero bit keeps", d[0], 1);
    stop_clear(); chk("R8 irq low", {31'd0, irq}, 0);
    wr(A_COUNT, 10); wr(A_CTRL, 1); step(4);
    rd(A_FLAGS, d); chk("R6 compare off", d, 0);

    // R11 capture
    stop_clear(); c = $urandom; wr(A_COUNT, c); wr(A_CTRL, 32'h100);
    cap_in = 1'b1; step(1);
    rd(A_CAPT, d); chk("R11 rising capture", d, c);
    rd(A_FLAGS, d); chk("R11 flag", d, 4);
    wr(A_FLAGS, 4); wr(A_COUNT, c + 5);
    cap_in = 1'b0; step(1);
    rd(A_CAPT, d); chk("R11 falling ignored", d, c);
    rd(A_FLAGS, d); chk("R11 no flag", d, 0);
    wr(A_CTRL, 32'h300); cap_in = 1'b1; step(1);
    rd(A_CAPT, d); chk("R11 both edges", d, c + 5);

    // R10 idle level with trigger none
    stop_clear(); wr(A_CTRL, 32'h80); step(1);
    chk("R10 idle high", {31'd0, pwm_out}, 1);
    wr(A_CTRL, 0); step(1);

    // R9 toggle on overflow
    wr(A_COUNT, 32'hFFFF_FFFE); wr(A_RELD, 32'hFFFF_FFFE);
    wr(A_CTRL, 32'h1403);
    step(1); chk("R9 before ovf", {31'd0, pwm_out}, 0);
    step(1); chk("R9 toggle 1", {31'd0, pwm_out}, 1);
    step(2); chk("R9 toggle 2", {31'd0, pwm_out}, 0);

    // R10 pulse, idle high
    wr(A_CTRL, 0); wr(A_COUNT, 32'hFFFF_FFFE); wr(A_CTRL, 32'h0483);
    step(1); chk("R10 idle", {31'd0, pwm_out}, 1);
    step(1); chk("R10 pulse", {31'd0, pwm_out}, 0);
    step(1); chk("R10 pulse ends", {31'd0, pwm_out}, 1);

    // R9 overflow and match trigger
    wr(A_CTRL, 0); wr(A_COUNT, 32'hFFFF_FFFE); wr(A_CMP, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h1843);
    step(1); chk("R9 match toggle", {31'd0, pwm_out}, 1);
    step(1); chk("R9 ovf toggle", {31'd0, pwm_out}, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule